// File: doc/BRIEF.md
# In-Order Load Return Sequencer

This block sits between a load issue stage and the integer register writeback. Each cycle it may accept one load. The load carries an access size, a signed/unsigned flag, the low three address bits, a destination tag, a hit flag from the cache model, and the 64-bit doubleword that the cache will deliver for that access. The cache model supplies either hit data or refill data in that doubleword. The block checks the alignment, picks out and extends the addressed field, and works out when the result is due. It then sends the results to a single writeback port, one result per cycle, strictly in the order the loads were accepted.

The result is due after a latency that depends on the load. The base latency is 2 cycles. A signed load narrower than a doubleword takes 3 cycles. A miss adds `MISS_PENALTY` cycles. Because results leave in order, a hit that follows a miss waits behind it. After a slow signed load, any loads that arrive in back-to-back cycles are also given the 3-cycle slot, so two results never compete for the port in the same cycle. An access that is not aligned to its size is not queued. Instead, the block raises a trap pulse carrying the load's tag.

A two-state machine holds the return mode. In `MODE_NORMAL`, latencies are as listed above. The transition "slow-issue" goes from `MODE_NORMAL` to `MODE_DELAYED` when a signed narrow load is accepted. In `MODE_DELAYED`, every accepted load uses the 3-cycle base. The transition "chain" keeps the machine in `MODE_DELAYED` on any accepted load. The transition "gap" returns it to `MODE_NORMAL` on a cycle with no accepted load. Reset forces `MODE_NORMAL`.

Top module: `load_return_seq`

## Requirements
- R1: An aligned hit load issued in `MODE_NORMAL` that is not a signed narrow load raises `wb_valid` in cycle issue+2. This includes unsigned loads of any size and signed doubleword loads.
- R2: An aligned signed hit load of byte (size 0), half (size 1) or word (size 2) raises `wb_valid` in cycle issue+3.
- R3: While the mode is `MODE_DELAYED`, any accepted hit load gets a base latency of 3. The mode enters `MODE_DELAYED` when a signed narrow load is accepted, stays there on every cycle in which a load is accepted, and falls to `MODE_NORMAL` after any cycle with no accepted load. A trapped load does not count as accepted.
- R4: A load issued with `ld_hit` low adds `MISS_PENALTY` cycles (default 8) to its base latency.
- R5: Results leave in acceptance order and at most one per cycle. Each result appears at the later of two cycles: its own due cycle, or the cycle after the previous result. No result appears early.
- R6: A load with `ld_addr` not a multiple of its size in bytes (size 1: 2, size 2: 4, size 3: 8) raises `trap_valid` with `trap_tag` equal to its tag in cycle issue+1. It never produces a `wb_valid` pulse.
- R7: Byte lanes are big-endian: address offset a selects bits [63-8a -: 8·bytes] of `ld_line`. Unsigned narrow results are zero-extended to 64 bits. A doubleword returns `ld_line` unchanged.
- R8: Signed narrow results are sign-extended from bit 7, 15 or 31 of the selected field.
- R9: At most `DEPTH` (8) accepted loads are held. `ld_ready` is low in any cycle in which 8 are held, even if one leaves that cycle. A load offered while `ld_ready` is low is ignored and never returns.
- R10: A synchronous reset empties the queue, clears `wb_valid` and `trap_valid`, sets `ld_ready`, and forces `MODE_NORMAL`. Any load offered during the reset cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_valid | input | 1 | A load is offered this cycle |
| ld_ready | output | 1 | The block can accept a load this cycle |
| ld_size | input | 2 | 0 byte, 1 half, 2 word, 3 doubleword |
| ld_signed | input | 1 | Sign-extend the result |
| ld_addr | input | 3 | Byte offset within the doubleword |
| ld_tag | input | TAG_W | Destination tag |
| ld_hit | input | 1 | 1 hit, 0 miss |
| ld_line | input | 64 | Doubleword delivered for this access |
| wb_valid | output | 1 | Writeback result valid |
| wb_tag | output | TAG_W | Tag of the returning load |
| wb_data | output | 64 | Extended load result |
| trap_valid | output | 1 | Misalignment trap pulse |
| trap_tag | output | TAG_W | Tag of the trapping load |

## Verification
A result is due in cycle issue+2, or issue+3 for a signed narrow load or one accepted in delayed mode, with `MISS_PENALTY` added for a miss, but never before the cycle after the previous result. A trap is due in cycle issue+1. The bench keeps a cycle count and gives every accepted load an expected return cycle from this rule. Between clock edges it checks that `wb_valid` is high exactly when the oldest expected load is due, and low otherwise. It checks trap timing the same way, and it checks `ld_ready` against its own count of held loads.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    localparam int unsigned LINE_W = 64;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } ld_size_e;

    typedef enum logic {
        MODE_NORMAL  = 1'b0,
        MODE_DELAYED = 1'b1
    } ret_mode_e;

    // signed access narrower than a doubleword: needs the slow return slot
    function automatic logic narrow_signed(input logic [1:0] sz, input logic sg);
        return sg && (sz != SZ_DWORD);
    endfunction

endpackage

// File: rtl/lrs_format.sv
module lrs_format
    import lrs_pkg::*;
(
    input  logic [1:0]        size,
    input  logic              sgn,
    input  logic [2:0]        addr,
    input  logic [LINE_W-1:0] line,
    output logic              misaligned,
    output logic [LINE_W-1:0] result
);

    logic [3:0]        nbytes;
    logic [3:0]        span;
    logic [6:0]        shamt;
    logic [LINE_W-1:0] field;

    always_comb begin
        nbytes     = 4'd1 << size;
        misaligned = (({1'b0, addr}) & (nbytes - 4'd1)) != 4'd0;
        // bytes to the right of the field in big-endian lane order
        span       = 4'd8 - {1'b0, addr} - nbytes;
        shamt      = {span, 3'b000};
        field      = line >> shamt;
    end

    always_comb begin
        unique case (ld_size_e'(size))
            SZ_BYTE:  result = sgn ? {{(LINE_W-8){field[7]}},   field[7:0]}
                                   : {{(LINE_W-8){1'b0}},       field[7:0]};
            SZ_HALF:  result = sgn ? {{(LINE_W-16){field[15]}}, field[15:0]}
                                   : {{(LINE_W-16){1'b0}},      field[15:0]};
            SZ_WORD:  result = sgn ? {{(LINE_W-32){field[31]}}, field[31:0]}
                                   : {{(LINE_W-32){1'b0}},      field[31:0]};
            SZ_DWORD: result = line;
            default:  result = line;
        endcase
    end

endmodule

// File: rtl/lrs_mode_fsm.sv
module lrs_mode_fsm
    import lrs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic slow,
    output logic delayed
);

    ret_mode_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= MODE_NORMAL;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_NORMAL:  state_d = (accept && slow) ? MODE_DELAYED : MODE_NORMAL;
            MODE_DELAYED: state_d = accept ? MODE_DELAYED : MODE_NORMAL;
            default:      state_d = MODE_NORMAL;
        endcase
    end

    always_comb begin
        delayed = (state_q == MODE_DELAYED);
    end

    AST_GAP_CLEARS_MODE: assert property (@(posedge clk) disable iff (rst)
        !accept |=> !delayed); // R3

    AST_CHAIN_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
        (delayed && accept) |=> delayed); // R3

endmodule

// File: rtl/lrs_queue.sv
module lrs_queue
    import lrs_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TAG_W = 5,
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [TAG_W-1:0]  push_tag,
    input  logic [LINE_W-1:0] push_data,
    input  logic [CNT_W-1:0]  push_wait,
    output logic              full,
    output logic              wb_valid,
    output logic [TAG_W-1:0]  wb_tag,
    output logic [LINE_W-1:0] wb_data
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);

    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [LINE_W-1:0] data_q [DEPTH];
    logic [CNT_W-1:0]  wait_v [DEPTH];
    logic [IDX_W-1:0]  head_q, tail_q;
    logic [OCC_W-1:0]  occ_q;
    logic              pop;

    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + IDX_W'(1);
    endfunction

    assign full = (occ_q == OCC_W'(DEPTH));
    assign pop  = (occ_q != '0) && (wait_v[head_q] == '0);

    // per-slot countdown to the due cycle
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [CNT_W-1:0] wait_r;
        always_ff @(posedge clk) begin
            if (rst)                                 wait_r <= '0;
            else if (push && tail_q == IDX_W'(i))    wait_r <= push_wait;
            else if (wait_r != '0)                   wait_r <= wait_r - CNT_W'(1);
        end
        assign wait_v[i] = wait_r;
    end

    always_ff @(posedge clk) begin
        if (push) begin
            tag_q[tail_q]  <= push_tag;
            data_q[tail_q] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
        end else begin
            if (push) tail_q <= bump(tail_q);
            if (pop)  head_q <= bump(head_q);
            occ_q <= occ_q + OCC_W'(push) - OCC_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid <= 1'b0;
            wb_tag   <= '0;
            wb_data  <= '0;
        end else begin
            wb_valid <= pop;
            if (pop) begin
                wb_tag  <= tag_q[head_q];
                wb_data <= data_q[head_q];
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> (occ_q < OCC_W'(DEPTH))); // R9

    AST_HEAD_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
        (occ_q != '0 && wait_v[head_q] != '0) |=> !wb_valid); // R5

endmodule

// File: rtl/load_return_seq.sv
module load_return_seq
    import lrs_pkg::*;
#(
    parameter int TAG_W        = 5,
    parameter int DEPTH        = 8,
    parameter int MISS_PENALTY = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    output logic              ld_ready,
    input  logic [1:0]        ld_size,
    input  logic              ld_signed,
    input  logic [2:0]        ld_addr,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic              ld_hit,
    input  logic [LINE_W-1:0] ld_line,
    output logic              wb_valid,
    output logic [TAG_W-1:0]  wb_tag,
    output logic [LINE_W-1:0] wb_data,
    output logic              trap_valid,
    output logic [TAG_W-1:0]  trap_tag
);

    // countdown holds (latency - 2): at most 1 + MISS_PENALTY
    localparam int CNT_W = $clog2(MISS_PENALTY + 2);

    logic              misaligned;
    logic [LINE_W-1:0] fmt_data;
    logic              q_full;
    logic              issue, accept, slow, delayed;
    logic [CNT_W-1:0]  wait_init;

    lrs_format u_fmt (
        .size       (ld_size),
        .sgn        (ld_signed),
        .addr       (ld_addr),
        .line       (ld_line),
        .misaligned (misaligned),
        .result     (fmt_data)
    );

    assign ld_ready = !q_full;
    assign issue    = ld_valid && ld_ready;
    assign accept   = issue && !misaligned;
    assign slow     = narrow_signed(ld_size, ld_signed);

    lrs_mode_fsm u_mode (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .slow    (slow),
        .delayed (delayed)
    );

    always_comb begin
        wait_init = (slow || delayed) ? CNT_W'(1) : CNT_W'(0);
        if (!ld_hit) wait_init = wait_init + CNT_W'(MISS_PENALTY);
    end

    lrs_queue #(
        .DEPTH (DEPTH),
        .TAG_W (TAG_W),
        .CNT_W (CNT_W)
    ) u_q (
        .clk       (clk),
        .rst       (rst),
        .push      (accept),
        .push_tag  (ld_tag),
        .push_data (fmt_data),
        .push_wait (wait_init),
        .full      (q_full),
        .wb_valid  (wb_valid),
        .wb_tag    (wb_tag),
        .wb_data   (wb_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_valid <= 1'b0;
            trap_tag   <= '0;
        end else begin
            trap_valid <= issue && misaligned;
            if (issue && misaligned) trap_tag <= ld_tag;
        end
    end

    AST_TRAP_NEXT: assert property (@(posedge clk) disable iff (rst)
        (issue && misaligned) |=> (trap_valid && trap_tag == $past(ld_tag))); // R6

    AST_SLOW_ENTERS_DELAY: assert property (@(posedge clk) disable iff (rst)
        (accept && slow) |=> delayed); // R3

    AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && !ld_ready) |=> !trap_valid); // R9

endmodule

// File: tb/sim_load_return_seq.sv
`timescale 1ns/1ps
module sim_load_return_seq;

    localparam int TAG_W = 5;
    localparam int DEPTH = 8;
    localparam int PEN   = 8;
    localparam int QN    = 4096;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ld_valid = 1'b0;
    logic              ld_ready;
    logic [1:0]        ld_size = '0;
    logic              ld_signed = 1'b0;
    logic [2:0]        ld_addr = '0;
    logic [TAG_W-1:0]  ld_tag = '0;
    logic              ld_hit = 1'b1;
    logic [63:0]       ld_line = '0;
    logic              wb_valid;
    logic [TAG_W-1:0]  wb_tag;
    logic [63:0]       wb_data;
    logic              trap_valid;
    logic [TAG_W-1:0]  trap_tag;

    always #2 clk = ~clk;

    load_return_seq #(.TAG_W(TAG_W), .DEPTH(DEPTH), .MISS_PENALTY(PEN)) u0 (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ready(ld_ready),
        .ld_size(ld_size), .ld_signed(ld_signed), .ld_addr(ld_addr),
        .ld_tag(ld_tag), .ld_hit(ld_hit), .ld_line(ld_line),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .trap_valid(trap_valid), .trap_tag(trap_tag)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;

    // expected-result queue
    int          e_tag  [QN];
    logic [63:0] e_data [QN];
    int          e_cyc  [QN];
    string       e_treq [QN];
    string       e_dreq [QN];
    int qh = 0, qt = 0, last_ret = 0;
    bit m_delayed = 0;
    int trap_cyc = -1, trap_tag_e = 0;
    int tag_ctr = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual=%h expected=%h", req, what, cyc, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_data(input logic [1:0] sz, input logic sg,
                                             input logic [2:0] ad, input logic [63:0] ln);
        int nb;
        int sh;
        logic [63:0] f;
        nb = 1 << sz;
        sh = 8 * (8 - int'(ad) - nb);
        f  = ln >> sh;
        case (sz)
            2'd0:    return sg ? {{56{f[7]}},  f[7:0]}  : {56'd0, f[7:0]};
            2'd1:    return sg ? {{48{f[15]}}, f[15:0]} : {48'd0, f[15:0]};
            2'd2:    return sg ? {{32{f[31]}}, f[31:0]} : {32'd0, f[31:0]};
            default: return ln;
        endcase
    endfunction

    // called at a falling edge: check outputs of this cycle, drive inputs, advance
    task automatic step(input logic v, input logic [1:0] sz, input logic sg,
                        input logic [2:0] ad, input logic hit, input logic [63:0] ln);
        bit exp_ready, mis, slow, acc;
        int lat, due, ret, nb, idx;
        if (qh != qt && e_cyc[qh % QN] == cyc) begin
            idx = qh % QN;
            check(wb_valid == 1'b1, e_treq[idx], "wb_valid due", 64'(wb_valid), 64'd1);
            check(wb_tag == TAG_W'(e_tag[idx]), e_treq[idx], "wb_tag", 64'(wb_tag), 64'(e_tag[idx]));
            check(wb_data == e_data[idx], e_dreq[idx], "wb_data", wb_data, e_data[idx]);
            qh++;
        end else begin
            check(wb_valid == 1'b0, "R5", "wb_valid not due", 64'(wb_valid), 64'd0);
        end
        if (trap_cyc == cyc)
            check(trap_valid && trap_tag == TAG_W'(trap_tag_e), "R6", "trap pulse",
                  {trap_valid, 58'd0, trap_tag}, {1'b1, 58'd0, TAG_W'(trap_tag_e)});
        else
            check(trap_valid == 1'b0, "R6", "no trap", 64'(trap_valid), 64'd0);
        exp_ready = (qt - qh) < DEPTH;
        check(ld_ready == exp_ready, "R9", "ld_ready", 64'(ld_ready), 64'(exp_ready));

        ld_valid  = v;
        ld_size   = sz;
        ld_signed = sg;
        ld_addr   = ad;
        ld_hit    = hit;
        ld_line   = ln;
        ld_tag    = TAG_W'(tag_ctr);
        acc = 0;
        slow = 0;
        if (v && exp_ready) begin
            nb  = 1 << sz;
            mis = (int'(ad) % nb) != 0;
            if (mis) begin
                trap_cyc   = cyc + 1;
                trap_tag_e = tag_ctr % (1 << TAG_W);
            end else begin
                acc  = 1;
                slow = sg && (sz != 2'd3);
                lat  = (slow || m_delayed) ? 3 : 2;
                due  = cyc + lat + (hit ? 0 : PEN);
                ret  = (due > last_ret) ? due : last_ret + 1;
                idx  = qt % QN;
                e_tag[idx]  = tag_ctr % (1 << TAG_W);
                e_data[idx] = exp_data(sz, sg, ad, ln);
                e_cyc[idx]  = ret;
                e_treq[idx] = (ret > due) ? "R5" : (!hit) ? "R4" : slow ? "R2" :
                              m_delayed ? "R3" : "R1";
                e_dreq[idx] = slow ? "R8" : "R7";
                qt++;
                last_ret = ret;
            end
            tag_ctr++;
        end
        m_delayed = acc && (slow || m_delayed);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 2'd0, 1'b0, 3'd0, 1'b1, 64'd0);
    endtask

    // reset for one cycle while a load is offered; that load must vanish
    task automatic pulse_reset(input logic v, input logic [1:0] sz, input logic sg);
        rst       = 1'b1;
        ld_valid  = v;
        ld_size   = sz;
        ld_signed = sg;
        ld_addr   = 3'd0;
        ld_hit    = 1'b1;
        ld_tag    = TAG_W'(tag_ctr);
        @(negedge clk);
        rst      = 1'b0;
        ld_valid = 1'b0;
        qh = qt;
        trap_cyc  = -1;
        m_delayed = 0;
        last_ret  = 0;
        // R10: state right after reset
        check(wb_valid == 1'b0, "R10", "wb_valid after reset", 64'(wb_valid), 64'd0);
        check(ld_ready == 1'b1, "R10", "ld_ready after reset", 64'(ld_ready), 64'd1);
    endtask

    logic [31:0] lfsr = 32'hACE1_2468;

    initial begin : main
        logic [63:0] base_line;
        @(negedge clk);
        @(negedge clk);
        pulse_reset(1'b0, 2'd0, 1'b0);
        check(trap_valid == 1'b0, "R10", "trap after reset", 64'(trap_valid), 64'd0);
        idle(2);

        // sweep of every size, sign and offset, isolated hits (R1 R2 R6 R7 R8)
        base_line = 64'h8172_A354_C736_E918;
        for (int inv = 0; inv < 2; inv++)
            for (int sz = 0; sz < 4; sz++)
                for (int sg = 0; sg < 2; sg++)
                    for (int ad = 0; ad < 8; ad++) begin
                        step(1'b1, 2'(sz), 1'(sg), 3'(ad), 1'b1,
                             inv != 0 ? ~base_line : base_line);
                        idle(3);
                    end

        // delayed mode chain, then a gap (R3)
        step(1'b1, 2'd0, 1'b1, 3'd3, 1'b1, base_line);
        step(1'b1, 2'd2, 1'b0, 3'd4, 1'b1, base_line);
        step(1'b1, 2'd1, 1'b0, 3'd2, 1'b1, base_line);
        step(1'b1, 2'd3, 1'b0, 3'd0, 1'b1, base_line);
        idle(1);
        step(1'b1, 2'd2, 1'b0, 3'd0, 1'b1, base_line);
        idle(5);

        // miss followed by hits held behind it (R4 R5)
        step(1'b1, 2'd3, 1'b0, 3'd0, 1'b0, 64'h0123_4567_89AB_CDEF);
        step(1'b1, 2'd0, 1'b0, 3'd7, 1'b1, 64'h0123_4567_89AB_CDEF);
        step(1'b1, 2'd1, 1'b1, 3'd6, 1'b1, 64'h0123_4567_89AB_CDEF);
        step(1'b1, 2'd2, 1'b0, 3'd0, 1'b1, 64'h0123_4567_89AB_CDEF);
        idle(16);

        // signed miss in a chain, misaligned load breaking the chain (R3 R4 R6)
        step(1'b1, 2'd1, 1'b1, 3'd0, 1'b0, base_line);
        step(1'b1, 2'd2, 1'b0, 3'd1, 1'b1, base_line);
        step(1'b1, 2'd2, 1'b0, 3'd4, 1'b1, base_line);
        idle(16);

        // fill the queue with misses; two are refused (R9)
        for (int i = 0; i < 10; i++)
            step(1'b1, 2'd3, 1'b0, 3'd0, 1'b0, {32'(i), 32'hFEED_0000});
        idle(24);

        // reset while in delayed mode with a load offered (R10)
        step(1'b1, 2'd3, 1'b0, 3'd0, 1'b0, base_line);
        step(1'b1, 2'd0, 1'b1, 3'd1, 1'b1, base_line);
        pulse_reset(1'b1, 2'd0, 1'b1);
        step(1'b1, 2'd2, 1'b0, 3'd4, 1'b1, base_line);
        idle(16);

        // pseudo-random traffic
        for (int i = 0; i < 600; i++) begin
            logic [2:0] ad;
            logic [1:0] sz;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            sz = lfsr[3:2];
            ad = lfsr[7:5];
            if (lfsr[10:8] != 3'd0) ad = ad & ~(3'((1 << sz) - 1));
            step(lfsr[0] | lfsr[1], sz, lfsr[4], ad, lfsr[13:11] != 3'd0,
                 {lfsr, lfsr ^ 32'h5A3C_96E1});
        end
        idle(40);
        check(qh == qt, "R5", "all results returned", 64'(qt - qh), 64'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : watchdog
        #800000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule